// File: doc/BRIEF.md
# Handshaked Serial Byte Transceiver

This block is the host end of a byte-wide serial link to a power-management microcontroller. The peer supplies the shift clock. Each byte is framed by a two-wire handshake: the host pulls an active-low request line, and the peer answers on an active-low acknowledge line. A host-side sequencer asks for one byte at a time. It either offers a byte to send or asks for a byte to receive. It then waits for a one-cycle pulse that reports success or timeout.

To send, the shift register is loaded with the byte and request is pulled low. To receive, the register is cleared and request is pulled low. The peer then clocks eight bits, most significant bit first. The block samples each bit on the rising edge of that clock after synchronizing it. Once the eighth bit has shifted, request is released. The block then waits for acknowledge to return high. If acknowledge stays low for a parameterized number of system clocks, the block gives up. If acknowledge is already high when the shift completes, the block raises a warning pulse.

Top module: `pmlink_xcvr`

## Requirements
- R1: While in reset and whenever the block is idle, `req_n` is 1 and `busy` is 0. After reset, `done`, `timeout`, `ack_warn` and `sdata_oe` are 0.
- R2: When the block is idle, a `tx_start` or `rx_start` pulse makes `req_n` 0 and `busy` 1 on the next cycle. For a transmit, `sdata_oe` is 1 in that cycle and `sdata_out` shows bit 7 of `tx_byte`. For a receive, `sdata_oe` stays 0.
- R3: In a transmit, `sdata_out` presents the byte most significant bit first. It moves to the next bit after each synchronized rising edge of `sclk`.
- R4: In a receive, the register starts cleared. `sdata_in` is sampled at each synchronized rising edge of `sclk`, and the first bit lands in bit 7. `rx_byte` changes only at the end of a receive, and a transmit leaves it unchanged.
- R5: On the eighth synchronized `sclk` rising edge, `req_n` returns to 1 on the next cycle.
- R6: After request is released, a synchronized `ack_n` of 1 gives a one-cycle `done` pulse, and the block is idle in that same cycle.
- R7: If `ack_n` stays 0 for `TMO_CYC` clocks after request is released, the block pulses `timeout` for one cycle instead of `done`. It returns to idle with `req_n` at 1.
- R8: If the synchronized `ack_n` is already 1 when the eighth bit shifts, `ack_warn` pulses for one cycle. The transfer then completes with `done`.
- R9: Start pulses that arrive while `busy` is 1 have no effect. If `tx_start` and `rx_start` arrive together while idle, the block performs a transmit.
- R10: `done` and `timeout` are never 1 in the same cycle. Each transfer ends with exactly one of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_start | input | 1 | Pulse: send `tx_byte` |
| rx_start | input | 1 | Pulse: receive one byte |
| tx_byte | input | DATA_W | Byte to transmit |
| busy | output | 1 | A transfer is in progress |
| rx_byte | output | DATA_W | Last byte received |
| done | output | 1 | Pulse: transfer finished with acknowledge high |
| timeout | output | 1 | Pulse: acknowledge did not return high in time |
| ack_warn | output | 1 | Pulse: acknowledge was high at shift completion |
| req_n | output | 1 | Active-low request to the peer |
| ack_n | input | 1 | Active-low acknowledge from the peer |
| sclk | input | 1 | Shift clock driven by the peer |
| sdata_in | input | 1 | Serial data from the peer |
| sdata_out | output | 1 | Serial data to the peer |
| sdata_oe | output | 1 | Drive enable for `sdata_out` during a transmit |

## Verification
The bound checker watches several rules on every cycle:
- request is high whenever the block is idle;
- a start from idle pulls request low;
- request is released right after the last bit;
- `done` and `timeout` never fire together;
- `done` follows a synchronized high acknowledge;
- the warning pulse only follows the last bit;
- the received byte holds steady outside its capture event.

Some behaviours appear only in the bench's scenarios. These include the bit order of the bytes actually shifted over the wire and the round-trip value of received bytes under random clock rates. They also include a timeout landing close to `TMO_CYC` cycles, and start pulses being ignored in mid-transfer.

// File: rtl/pmlink_pkg.sv
package pmlink_pkg;

  typedef enum logic [1:0] {
    LNK_IDLE  = 2'd0,
    LNK_SHIFT = 2'd1,
    LNK_WAIT  = 2'd2
  } lnk_state_t;

  // Commands from the controller to the shift register.
  typedef struct packed {
    logic load;     // take tx_byte
    logic clear;    // dummy clear before a receive
    logic shift;    // one synchronized sclk rising edge
    logic last;     // this shift is the final bit
    logic tx_mode;  // 1: shift out, 0: shift in
  } sh_cmd_t;

endpackage

// File: rtl/pmlink_sync.sv
module pmlink_sync #(
  parameter int              W       = 1,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= RST_VAL;
    else        stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[i] <= RST_VAL;
      else        stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/pmlink_shifter.sv
module pmlink_shifter
  import pmlink_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sh_cmd_t           cmd,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              din_s,
  output logic              sdo,
  output logic [DATA_W-1:0] rx_byte,
  output logic              cap_evt
);

  logic [DATA_W-1:0] sh_q;
  logic [DATA_W-1:0] sh_nxt;

  // Shift left by one: the top bit leaves first, the new bit enters at the bottom.
  function automatic logic [DATA_W-1:0] shl_in(input logic [DATA_W-1:0] cur,
                                               input logic bit_in);
    return {cur[DATA_W-2:0], bit_in};
  endfunction

  assign sh_nxt  = shl_in(sh_q, cmd.tx_mode ? 1'b0 : din_s);
  assign cap_evt = cmd.shift && cmd.last && !cmd.tx_mode;
  assign sdo     = sh_q[DATA_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else if (cmd.load) begin
      sh_q <= tx_byte;
    end else if (cmd.clear) begin
      sh_q <= '0;
    end else if (cmd.shift) begin
      sh_q <= sh_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rx_byte <= '0;
    else if (cap_evt) rx_byte <= sh_nxt;
  end

endmodule

// File: rtl/pmlink_ctrl.sv
module pmlink_ctrl
  import pmlink_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int TMO_CYC = 2000
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    tx_start,
  input  logic    rx_start,
  input  logic    sclk_rise,
  input  logic    ack_hi_s,
  output sh_cmd_t cmd,
  output logic    shift_last,
  output logic    busy,
  output logic    in_shift,
  output logic    req_n,
  output logic    done,
  output logic    timeout,
  output logic    ack_warn
);

  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int TMR_W = $clog2(TMO_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(TMO_CYC - 1);

  lnk_state_t       st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [TMR_W-1:0] tmr_q;
  logic             mode_tx_q;
  logic             req_n_q, done_q, tmo_q, warn_q;
  logic             idle, go;

  function automatic logic bit_is_last(input logic [CNT_W-1:0] c);
    return c == CNT_LAST;
  endfunction

  function automatic logic tmr_expired(input logic [TMR_W-1:0] t);
    return t == TMR_LAST;
  endfunction

  assign idle     = (st_q == LNK_IDLE);
  assign go       = idle && (tx_start || rx_start);
  assign busy     = !idle;
  assign in_shift = (st_q == LNK_SHIFT);

  assign cmd.load    = idle && tx_start;
  assign cmd.clear   = idle && !tx_start && rx_start;
  assign cmd.shift   = in_shift && sclk_rise;
  assign cmd.last    = bit_is_last(cnt_q);
  assign cmd.tx_mode = mode_tx_q;
  assign shift_last  = cmd.shift && cmd.last;

  assign req_n    = req_n_q;
  assign done     = done_q;
  assign timeout  = tmo_q;
  assign ack_warn = warn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= LNK_IDLE;
      cnt_q     <= '0;
      tmr_q     <= '0;
      mode_tx_q <= 1'b0;
      req_n_q   <= 1'b1;
      done_q    <= 1'b0;
      tmo_q     <= 1'b0;
      warn_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      tmo_q  <= 1'b0;
      warn_q <= 1'b0;
      unique case (st_q)
        LNK_IDLE: begin
          if (go) begin
            st_q      <= LNK_SHIFT;
            req_n_q   <= 1'b0;
            mode_tx_q <= tx_start;
            cnt_q     <= '0;
          end
        end
        LNK_SHIFT: begin
          if (cmd.shift) begin
            if (cmd.last) begin
              st_q    <= LNK_WAIT;
              req_n_q <= 1'b1;
              tmr_q   <= '0;
              warn_q  <= ack_hi_s;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        LNK_WAIT: begin
          if (ack_hi_s) begin
            done_q <= 1'b1;
            st_q   <= LNK_IDLE;
          end else if (tmr_expired(tmr_q)) begin
            tmo_q <= 1'b1;
            st_q  <= LNK_IDLE;
          end else begin
            tmr_q <= tmr_q + 1'b1;
          end
        end
        default: st_q <= LNK_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pmlink_xcvr.sv
module pmlink_xcvr
  import pmlink_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int TMO_CYC = 2000,
  parameter int SYNC_N  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_start,
  input  logic              rx_start,
  input  logic [DATA_W-1:0] tx_byte,
  output logic              busy,
  output logic [DATA_W-1:0] rx_byte,
  output logic              done,
  output logic              timeout,
  output logic              ack_warn,
  output logic              req_n,
  input  logic              ack_n,
  input  logic              sclk,
  input  logic              sdata_in,
  output logic              sdata_out,
  output logic              sdata_oe
);

  logic [2:0] raw_in, sync_out;
  logic       sclk_s, din_s, ack_hi_s;
  logic       sclk_d;
  logic       sclk_rise;
  logic       shift_last, in_shift, cap_evt;
  sh_cmd_t    cmd;

  // All three peer-driven lines share one synchronizer so data stays aligned with the clock.
  assign raw_in = {sclk, sdata_in, ack_n};

  pmlink_sync #(.W(3), .STAGES(SYNC_N), .RST_VAL(3'b111)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_in),
    .q     (sync_out)
  );

  assign {sclk_s, din_s, ack_hi_s} = sync_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_d <= 1'b1;
    else        sclk_d <= sclk_s;
  end

  assign sclk_rise = sclk_s && !sclk_d;

  pmlink_ctrl #(.DATA_W(DATA_W), .TMO_CYC(TMO_CYC)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_start   (tx_start),
    .rx_start   (rx_start),
    .sclk_rise  (sclk_rise),
    .ack_hi_s   (ack_hi_s),
    .cmd        (cmd),
    .shift_last (shift_last),
    .busy       (busy),
    .in_shift   (in_shift),
    .req_n      (req_n),
    .done       (done),
    .timeout    (timeout),
    .ack_warn   (ack_warn)
  );

  pmlink_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd     (cmd),
    .tx_byte (tx_byte),
    .din_s   (din_s),
    .sdo     (sdata_out),
    .rx_byte (rx_byte),
    .cap_evt (cap_evt)
  );

  assign sdata_oe = in_shift && cmd.tx_mode;

endmodule

// File: rtl/pmlink_xcvr_chk.sv
module pmlink_xcvr_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_start,
  input logic              rx_start,
  input logic              busy,
  input logic              req_n,
  input logic              done,
  input logic              timeout,
  input logic              ack_warn,
  input logic              sdata_oe,
  input logic              ack_hi_s,
  input logic              shift_last,
  input logic              cap_evt,
  input logic [DATA_W-1:0] rx_byte
);

  AST_IDLE_REQ_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> req_n) else $error("idle with request low"); // R1

  AST_START_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (tx_start || rx_start)) |=> (busy && !req_n)) else $error("start not taken"); // R2

  AST_TX_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && tx_start) |=> sdata_oe) else $error("transmit not chosen"); // R9

  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_evt |=> $stable(rx_byte)) else $error("rx_byte moved without capture"); // R4

  AST_REQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    shift_last |=> req_n) else $error("request not released"); // R5

  AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(ack_hi_s) && !busy)) else $error("done without ack high"); // R6

  AST_TMO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> (req_n && !busy)) else $error("timeout not idle"); // R7

  AST_WARN_AT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    ack_warn |-> $past(shift_last)) else $error("warn outside completion"); // R8

  AST_END_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, timeout})) else $error("done and timeout together"); // R10

endmodule

bind pmlink_xcvr pmlink_xcvr_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tx_start   (tx_start),
  .rx_start   (rx_start),
  .busy       (busy),
  .req_n      (req_n),
  .done       (done),
  .timeout    (timeout),
  .ack_warn   (ack_warn),
  .sdata_oe   (sdata_oe),
  .ack_hi_s   (ack_hi_s),
  .shift_last (shift_last),
  .cap_evt    (cap_evt),
  .rx_byte    (rx_byte)
);

// File: tb/tb_pmlink_xcvr.sv
module tb_pmlink_xcvr;

  localparam int CLK_PERIOD = 10;
  localparam int DW         = 8;
  localparam int TMO        = 300;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tx_start = 1'b0, rx_start = 1'b0;
  logic [DW-1:0] tx_byte = '0;
  logic          ack_n = 1'b1, sclk = 1'b1, sdata_in = 1'b0;
  logic          busy, done, timeout, ack_warn, req_n, sdata_out, sdata_oe;
  logic [DW-1:0] rx_byte;

  int checks = 0, fails = 0;
  int n_done = 0, n_tmo = 0, n_warn = 0;
  bit finished = 1'b0;

  pmlink_xcvr #(.DATA_W(DW), .TMO_CYC(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .tx_start(tx_start), .rx_start(rx_start),
    .tx_byte(tx_byte), .busy(busy), .rx_byte(rx_byte), .done(done),
    .timeout(timeout), .ack_warn(ack_warn), .req_n(req_n), .ack_n(ack_n),
    .sclk(sclk), .sdata_in(sdata_in), .sdata_out(sdata_out), .sdata_oe(sdata_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (rst_n) begin
      if (done)     n_done++;
      if (timeout)  n_tmo++;
      if (ack_warn) n_warn++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected first wire bit of a byte: its top bit.
  function automatic logic wire_first(input logic [DW-1:0] b);
    return b[DW-1];
  endfunction

  // Bit the peer places on the wire in slot i: most significant first.
  function automatic logic peer_bit(input logic [DW-1:0] b, input int i);
    return b[DW-1-i];
  endfunction

  task automatic start(input bit do_tx, input bit do_rx, input logic [DW-1:0] b);
    @(negedge clk);
    tx_start = do_tx; rx_start = do_rx; tx_byte = b;
    @(negedge clk);
    tx_start = 1'b0; rx_start = 1'b0;
  endtask

  // Peer model: answers request, clocks all bits, optionally releases acknowledge.
  task automatic peer(input bit drive_ack, input logic [DW-1:0] send, input int half,
                      input bit release_ack, output logic [DW-1:0] got);
    for (int w = 0; w < 100 && req_n !== 1'b0; w++) @(negedge clk);
    if (drive_ack) ack_n = 1'b0;
    got = '0;
    for (int i = 0; i < DW; i++) begin
      sclk = 1'b0;
      sdata_in = peer_bit(send, i);
      repeat (half) @(negedge clk);
      got = {got[DW-2:0], sdata_out};
      sclk = 1'b1;
      repeat (half) @(negedge clk);
    end
    if (release_ack) begin
      for (int w = 0; w < 50 && req_n !== 1'b1; w++) @(negedge clk);
      repeat (2) @(negedge clk);
      ack_n = 1'b1;
    end
  endtask

  task automatic wait_idle();
    for (int w = 0; w < TMO + 200 && busy === 1'b1; w++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic xfer(input bit do_tx, input logic [DW-1:0] b, input int half);
    logic [DW-1:0] prev_rx, got;
    int d0;
    prev_rx = rx_byte;
    d0 = n_done;
    start(do_tx, !do_tx, b);
    chk(req_n === 1'b0 && busy === 1'b1, "R2 request", {busy, req_n}, 2'b10);
    chk(sdata_oe === do_tx, "R2 drive enable", sdata_oe, do_tx);
    if (do_tx) chk(sdata_out === wire_first(b), "R2 first bit", sdata_out, wire_first(b));
    peer(1'b1, b, half, 1'b1, got);
    wait_idle();
    chk(n_done == d0 + 1, "R6 done count", n_done, d0 + 1);
    chk(req_n === 1'b1 && busy === 1'b0, "R5 released idle", {busy, req_n}, 2'b01);
    if (do_tx) begin
      chk(got === b, "R3 wire byte", got, b);
      chk(rx_byte === prev_rx, "R4 rx kept on tx", rx_byte, prev_rx);
    end else begin
      chk(rx_byte === b, "R4 rx byte", rx_byte, b);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] got, prev;
    int d0, t0, w0, c;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(req_n === 1'b1 && busy === 1'b0, "R1 in reset", {busy, req_n}, 2'b01);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk({done, timeout, ack_warn, sdata_oe} === 4'b0, "R1 after reset",
        {done, timeout, ack_warn, sdata_oe}, 0);
    chk(req_n === 1'b1, "R1 req idle", req_n, 1);

    // Directed patterns
    xfer(1'b1, 8'hA5, 4);
    xfer(1'b0, 8'h3C, 4);
    xfer(1'b1, 8'h00, 5);
    xfer(1'b0, 8'hFF, 6);
    xfer(1'b1, 8'h80, 4);
    xfer(1'b0, 8'h01, 7);

    // Random transfers
    for (int k = 0; k < 24; k++) begin
      xfer(1'($urandom % 2), DW'($urandom), 4 + int'($urandom % 4));
    end

    // R9: starts during a transfer are ignored
    prev = rx_byte;
    start(1'b1, 1'b0, 8'h81);
    @(negedge clk);
    tx_start = 1'b1; rx_start = 1'b1; tx_byte = 8'h7E;
    @(negedge clk);
    tx_start = 1'b0; rx_start = 1'b0;
    peer(1'b1, 8'h55, 4, 1'b1, got);
    wait_idle();
    chk(got === 8'h81, "R9 mid-transfer start ignored", got, 8'h81);
    chk(rx_byte === prev, "R9 rx unchanged", rx_byte, prev);

    // R9: simultaneous starts pick transmit
    start(1'b1, 1'b1, 8'h5A);
    chk(sdata_oe === 1'b1, "R9 tx priority", sdata_oe, 1);
    peer(1'b1, 8'h00, 4, 1'b1, got);
    wait_idle();
    chk(got === 8'h5A, "R9 tx priority byte", got, 8'h5A);

    // R8: acknowledge never asserted
    d0 = n_done; w0 = n_warn;
    start(1'b0, 1'b1, 8'h00);
    peer(1'b0, 8'hC3, 4, 1'b0, got);
    wait_idle();
    chk(n_warn == w0 + 1, "R8 warn pulse", n_warn, w0 + 1);
    chk(n_done == d0 + 1, "R8 done after warn", n_done, d0 + 1);
    chk(rx_byte === 8'hC3, "R8 rx byte", rx_byte, 8'hC3);

    // R7: acknowledge held low
    d0 = n_done; t0 = n_tmo; c = 0;
    start(1'b1, 1'b0, 8'h96);
    peer(1'b1, 8'h00, 4, 1'b0, got);
    while (n_tmo == t0 && c < TMO + 100) begin
      @(negedge clk);
      c++;
    end
    chk(n_tmo == t0 + 1, "R7 timeout pulse", n_tmo, t0 + 1);
    chk(c >= TMO - 10 && c <= TMO + 10, "R7 timeout length", c, TMO);
    chk(n_done == d0, "R10 no done on timeout", n_done, d0);
    chk(req_n === 1'b1 && busy === 1'b0, "R7 idle after timeout", {busy, req_n}, 2'b01);
    ack_n = 1'b1;
    repeat (5) @(negedge clk);

    // Recovery after timeout
    xfer(1'b0, 8'h6E, 5);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule